// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of recent branch outcomes and a table of 2-bit saturating counters. A lookup takes the word-aligned program counter, XORs the bits just above the byte offset with the outcome history, and reads one counter. The upper half of the counter range means taken. The history value used for the lookup is also returned to the caller.

When a branch resolves, the caller sends back the branch PC, the real outcome and the history snapshot it received at lookup time. The counter chosen by that snapshot moves one step toward the outcome. The outcome bit also enters the live history register. After reset, the table is filled with weakly-not-taken counters one entry per cycle. A busy flag stays high until this fill is complete.

Top module: `gxp_predictor`

## Requirements
- R1: After reset the history is zero and `busy` stays high for exactly 2^IDX_W cycles. The table is filled during that time, and after it every entry holds 1 (weakly not-taken).
- R2: While `busy` is high, `pred_taken` is 0 and a resolve request changes neither the table nor the history.
- R3: The lookup index is `pc[IDX_W+1:2] XOR history`. PC bits 1:0 and bits above IDX_W+1 have no effect.
- R4: `pred_taken` is combinational in the current state. It is 1 when the indexed counter is 2 or 3 and 0 when the counter is 0 or 1.
- R5: A resolve moves the indexed counter up by one for taken and down by one for not-taken. The counter saturates at 3 and at 0.
- R6: A resolve shifts the outcome into history bit 0 (1 = taken), moves the older bits up by one place and drops the top bit. `pred_hist` always shows the live history.
- R7: The counter updated by a resolve is selected by `res_pc[IDX_W+1:2] XOR res_hist`, using the returned snapshot and not the live history.
- R8: If a lookup and a resolve hit the same entry in one cycle, the lookup returns the counter value from before the update. The new value is visible from the next cycle.
- R9: A branch that alternates taken / not-taken is predicted correctly on every occurrence once the history has filled and the two history contexts have trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | output | 1 | Table fill in progress |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | IDX_W | Live history, to be returned at resolve |
| res_valid | input | 1 | Resolve request this cycle |
| res_pc | input | PC_W | PC of the resolved branch |
| res_hist | input | IDX_W | History snapshot taken at lookup time |
| res_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The hardest case to reach from the ports is a lookup and a resolve landing on the same entry in the same cycle. Their indices are formed from different history values, so they only coincide when the stimulus is built for it. The bench keeps its own copy of the history. It picks a lookup PC equal to the target index XORed with that copy, and a resolve PC equal to the target index XORed with an unrelated snapshot. It does the same to test saturation on one chosen entry, while the live history keeps moving under it.

// File: rtl/gxp_pkg.sv
package gxp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;

  // one saturating step toward the observed outcome
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  // upper half of the range means taken
  function automatic logic ctr_dir(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/gxp_history.sv
module gxp_history #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
  end

endmodule

// File: rtl/gxp_index.sv
module gxp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);

  localparam int LSB = 2;
  localparam int MSB = IDX_W + LSB - 1;

  always_comb idx = pc[MSB:LSB] ^ hist;

endmodule

// File: rtl/gxp_table.sv
module gxp_table
  import gxp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic [IDX_W-1:0] up_idx,
  output ctr_t             up_old,
  input  logic             wr_en,
  input  ctr_t             wr_val,
  output logic             clearing,
  output logic [IDX_W-1:0] clr_ptr
);

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  ctr_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing <= 1'b1;
      clr_ptr  <= '0;
    end else if (clearing) begin
      clr_ptr <= clr_ptr + 1'b1;
      if (clr_ptr == LAST) clearing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clearing)   mem[clr_ptr] <= CTR_INIT;
    else if (wr_en) mem[up_idx]  <= wr_val;
  end

  always_comb begin
    rd_ctr = mem[rd_idx];
    up_old = mem[up_idx];
  end

endmodule

// File: rtl/gxp_predictor.sv
module gxp_predictor
  import gxp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_hist,
  input  logic             res_valid,
  input  logic [PC_W-1:0]  res_pc,
  input  logic [IDX_W-1:0] res_hist,
  input  logic             res_taken
);

  logic [IDX_W-1:0] hist_q;
  logic [IDX_W-1:0] pred_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [IDX_W-1:0] clr_ptr;
  ctr_t             rd_ctr;
  ctr_t             upd_old;
  ctr_t             upd_new;
  logic             clearing;
  logic             upd_fire;

  gxp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_pidx (
    .pc(pred_pc), .hist(hist_q), .idx(pred_idx)
  );

  gxp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_uidx (
    .pc(res_pc), .hist(res_hist), .idx(upd_idx)
  );

  gxp_table #(.IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_idx), .rd_ctr(rd_ctr),
    .up_idx(upd_idx), .up_old(upd_old),
    .wr_en(upd_fire), .wr_val(upd_new),
    .clearing(clearing), .clr_ptr(clr_ptr)
  );

  gxp_history #(.HIST_W(IDX_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_fire), .shift_bit(res_taken), .hist_q(hist_q)
  );

  always_comb begin
    busy       = clearing;
    upd_fire   = res_valid & ~clearing;
    upd_new    = ctr_step(upd_old, res_taken);
    pred_taken = ~clearing & ctr_dir(rd_ctr);
    pred_hist  = hist_q;
  end

endmodule

// File: rtl/gxp_checker.sv
module gxp_checker
  import gxp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             pred_taken,
  input logic [IDX_W-1:0] hist_q,
  input logic             upd_fire,
  input logic             res_taken,
  input ctr_t             upd_old,
  input ctr_t             upd_new,
  input logic [IDX_W-1:0] clr_ptr
);

  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r1_fill_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == (IDX_W+1)'(DEPTH)));

  a_r1_fill_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (clr_ptr == '0));

  a_r2_no_pred_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pred_taken);

  a_r2_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(hist_q));

  a_r6_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (hist_q == {$past(hist_q[IDX_W-2:0]), $past(res_taken)}));

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && res_taken) |->
      ((upd_old != 2'd3 && upd_new == upd_old + 2'd1) ||
       (upd_old == 2'd3 && upd_new == 2'd3)));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !res_taken) |->
      ((upd_old != 2'd0 && upd_new == upd_old - 2'd1) ||
       (upd_old == 2'd0 && upd_new == 2'd0)));

endmodule

bind gxp_predictor gxp_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pred_taken(pred_taken),
  .hist_q(hist_q), .upd_fire(upd_fire), .res_taken(res_taken),
  .upd_old(upd_old), .upd_new(upd_new), .clr_ptr(clr_ptr)
);

// File: tb/sim_gxp_predictor.sv
module sim_gxp_predictor;

  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam int DEPTH = 1 << IDX_W;
  localparam int HI_W  = PC_W - IDX_W - 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             busy;
  logic [PC_W-1:0]  pred_pc = '0;
  logic             pred_taken;
  logic [IDX_W-1:0] pred_hist;
  logic             res_valid = 1'b0;
  logic [PC_W-1:0]  res_pc = '0;
  logic [IDX_W-1:0] res_hist = '0;
  logic             res_taken = 1'b0;

  int checks = 0;
  int fails  = 0;
  int ref_ctr [DEPTH];
  logic [IDX_W-1:0] ref_hist;
  logic [31:0] lfsr = 32'hACE1_1357;

  always #4 clk = ~clk;

  gxp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .res_valid(res_valid), .res_pc(res_pc), .res_hist(res_hist),
    .res_taken(res_taken)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // PC whose index bits are (idx ^ h), with scrambled bits elsewhere
  function automatic logic [PC_W-1:0] pc_for(input int idx, input logic [IDX_W-1:0] h,
                                             input logic [31:0] junk);
    logic [IDX_W-1:0] mid;
    mid = IDX_W'(idx) ^ h;
    return {junk[HI_W-1:0], mid, junk[31:30]};
  endfunction

  function automatic logic ref_pred(input int idx);
    return ref_ctr[idx] > 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) ref_ctr[i] = 1;
    ref_hist = '0;
  endtask

  // drive a resolve for one cycle and advance the reference model
  task automatic drive_res(input logic [PC_W-1:0] pc, input logic [IDX_W-1:0] snap,
                           input logic t);
    int k;
    res_valid = 1'b1; res_pc = pc; res_hist = snap; res_taken = t;
    @(negedge clk);
    res_valid = 1'b0;
    k = int'(pc[IDX_W+1:2] ^ snap);
    if (t) ref_ctr[k] = (ref_ctr[k] >= 3) ? 3 : ref_ctr[k] + 1;
    else   ref_ctr[k] = (ref_ctr[k] <= 0) ? 0 : ref_ctr[k] - 1;
    ref_hist = {ref_hist[IDX_W-2:0], t};
  endtask

  task automatic look(input int idx, output logic p);
    lfsr = next_rand(lfsr);
    pred_pc = pc_for(idx, ref_hist, lfsr);
    #1;
    p = pred_taken;
  endtask

  // R1 / R2: reset, fill length, ignored resolves during fill
  task automatic t_reset();
    int n;
    logic p;
    rst_n = 1'b0;
    res_valid = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    res_valid = 1'b1; res_taken = 1'b1; res_pc = 32'h0000_0010; res_hist = 6'h3;
    #1;
    chk(busy === 1'b1, "R1 busy after reset", int'(busy), 1);
    chk(pred_taken === 1'b0, "R2 no prediction while busy", int'(pred_taken), 0);
    chk(pred_hist === '0, "R1 history cleared", int'(pred_hist), 0);
    n = 0;
    while (busy === 1'b1 && n < 4 * DEPTH) begin
      n++;
      @(negedge clk);
      #1;
      if (busy === 1'b1) chk(pred_taken === 1'b0, "R2 no prediction while busy", int'(pred_taken), 0);
    end
    res_valid = 1'b0;
    chk(n == DEPTH, "R1 busy length", n, DEPTH);
    chk(pred_hist === '0, "R2 history untouched by resolves during fill", int'(pred_hist), 0);
    for (int i = 0; i < DEPTH; i++) begin
      look(i, p);
      chk(p === 1'b0, "R1 entry initialised weakly not-taken", int'(p), 0);
    end
  endtask

  // R5 / R7 / R4: saturation at both ends on one entry, resolved via a foreign snapshot
  task automatic t_saturate();
    localparam int X = 5;
    logic [IDX_W-1:0] snap;
    logic p;
    logic [0:9] pattern;
    logic [0:9] expect_p;
    pattern  = 10'b1110_0000_11;
    expect_p = 10'b1111_0000_01;
    snap = 6'h2A;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      lfsr = next_rand(lfsr);
      drive_res(pc_for(X, snap, lfsr), snap, pattern[i]);
      look(X, p);
      chk(p === expect_p[i], "R5 saturating counter step", int'(p), int'(expect_p[i]));
      chk(p === ref_pred(X), "R7 update indexed by returned snapshot", int'(p), int'(ref_pred(X)));
    end
  endtask

  // R8: lookup and resolve on the same entry in the same cycle
  task automatic t_same_cycle();
    localparam int Y = 9;
    logic [IDX_W-1:0] snap;
    logic p;
    snap = 6'h11;
    @(negedge clk);
    lfsr = next_rand(lfsr);
    pred_pc = pc_for(Y, ref_hist, lfsr);
    res_valid = 1'b1; res_pc = pc_for(Y, snap, ~lfsr); res_hist = snap; res_taken = 1'b1;
    #1;
    chk(pred_taken === 1'b0, "R8 same-cycle lookup sees old value", int'(pred_taken), 0);
    drive_res(res_pc, snap, 1'b1);
    look(Y, p);
    chk(p === 1'b1, "R8 updated value visible next cycle", int'(p), 1);
  endtask

  // R9: alternating branch becomes predictable
  task automatic t_alternate();
    logic [PC_W-1:0] pc;
    logic [IDX_W-1:0] snap;
    logic outcome;
    t_reset_quiet();
    pc = 32'h0040_0104;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      outcome = i[0];
      pred_pc = pc;
      #1;
      snap = pred_hist;
      chk(pred_taken === ref_pred(int'(pc[IDX_W+1:2] ^ ref_hist)), "R4 prediction matches model",
          int'(pred_taken), int'(ref_pred(int'(pc[IDX_W+1:2] ^ ref_hist))));
      if (i >= 24) chk(pred_taken === outcome, "R9 alternating pattern predicted", int'(pred_taken), int'(outcome));
      drive_res(pc, snap, outcome);
    end
  endtask

  task automatic t_reset_quiet();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    while (busy !== 1'b0) @(negedge clk);
  endtask

  // R3 / R4 / R6: mixed traffic against the reference model
  task automatic t_random();
    logic [IDX_W-1:0] snap;
    logic t;
    int k;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      lfsr = next_rand(lfsr);
      pred_pc = lfsr;
      #1;
      k = int'(lfsr[IDX_W+1:2] ^ ref_hist);
      chk(pred_taken === ref_pred(k), "R3 index from pc bits xor history", int'(pred_taken), int'(ref_pred(k)));
      chk(pred_hist === ref_hist, "R6 history shift", int'(pred_hist), int'(ref_hist));
      snap = pred_hist;
      lfsr = next_rand(lfsr);
      t = (lfsr[3:0] > 4'd4);
      if (lfsr[7]) drive_res(pred_pc, snap, t);
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_saturate();
    t_same_cycle();
    t_alternate();
    t_random();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule